// File: doc/BRIEF.md
# Downstream Serial Frame Transmitter

This block serializes frames onto a one-wire synchronous downstream data line. Every bit period is marked by a single-cycle frame-clock enable pulse. The frame payload is the 32-bit concatenation of a low and a high 16-bit word. Bit 0 of the low word goes out first, and bit 15 of the high word would go out last.

There are two frame kinds.

- A command frame sends a programmable number of payload bits and then ends.
- A data frame sends all 32 bits. It is then followed by a passive phase of programmable length, during which the line is held low.

In triggered mode, each request pulse produces one frame. In repetition mode, frames follow one another automatically. A disable input stops new frames from starting but never cuts a running frame short. At the moment a frame starts, the frame kind, bit count, passive length and payload are all captured. After that, the inputs may change freely without affecting the frame in progress.

Top module: `dsf_tx`

## Requirements
- R1: A command frame with bit-count code N (0..32) drives payload bits 0..N-1 of {word_hi, word_lo} on sdo, low word first and least significant bit first. Each bit is held until one fclk_en pulse, which advances to the next bit.
- R2: Bit-count codes 33..63 behave exactly like 32.
- R3: A command frame with bit-count code 0 shifts nothing. It raises frame_done in the cycle after its start and never raises busy.
- R4: A data frame (cmd_frame = 0) sends all 32 payload bits and then a passive phase. The passive phase lasts 2 fclk_en periods for codes 0, 1 and 2, and lasts the code's value for codes 3..31. During the passive phase sdo is 0 and busy is 1. busy falls and frame_done pulses for one cycle on the edge of the final passive fclk_en.
- R5: The frame kind, bit count, passive length and both payload words are captured when a frame starts. Changing them during the frame does not alter that frame.
- R6: While chan_disable is 1, no frame starts, and a frame already running still completes. dis_status follows chan_disable one cycle later: 1 means disabled, 0 means enabled.
- R7: In triggered mode (rep_mode = 0), an idle, enabled channel starts a frame on the clock edge at which trigger is sampled high. Without a trigger, it stays idle.
- R8: In repetition mode (rep_mode = 1), an idle, enabled channel starts a frame on the next clock edge. This includes the edge right after a previous frame's frame_done.
- R9: A trigger seen while a frame runs is stored as a single pending request, and several such triggers collapse into one. The pending request starts a frame on the edge after the running frame ends. It is discarded if chan_disable is asserted before it is served.
- R10: After reset, busy, sdo and frame_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fclk_en | input | 1 | One-cycle pulse marking the end of a bit period |
| trigger | input | 1 | Frame request in triggered mode |
| rep_mode | input | 1 | 1 = repetition mode, 0 = triggered mode |
| chan_disable | input | 1 | 1 blocks new frames |
| cmd_frame | input | 1 | 1 = command frame, 0 = data frame |
| cmd_bits | input | 6 | Command frame bit-count code |
| passive_len | input | 5 | Data frame passive phase code |
| word_lo | input | 16 | Low payload word, sent first |
| word_hi | input | 16 | High payload word |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse when a frame ends |
| dis_status | output | 1 | Channel disabled status |

## Verification
The bench targets the bit-count edges: 0, 1, 16, 17, 32 and reserved codes above 32. A design with a wrong clamp or an off-by-one counter would send one bit too many or too few, or would wrap a reserved code to a short frame. It also drives passive codes 0 to 3 and 31, which catches a design that produces a zero- or one-period passive phase. The inputs are scrambled mid-frame, which exposes a design that reads live configuration or payload instead of shadow copies. Finally, the bench disables the channel mid-frame, with and without a queued trigger. This catches a design that aborts the running frame, lets a stale request start after re-enabling, or replays several queued triggers as several frames.

// File: rtl/dsf_tx.sv
module dsf_tx #(
  parameter int WORD_W      = 16,
  parameter int CNT_W       = 6,
  parameter int PAS_W       = 5,
  parameter int MIN_PASSIVE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fclk_en,
  input  logic              trigger,
  input  logic              rep_mode,
  input  logic              chan_disable,
  input  logic              cmd_frame,
  input  logic [CNT_W-1:0]  cmd_bits,
  input  logic [PAS_W-1:0]  passive_len,
  input  logic [WORD_W-1:0] word_lo,
  input  logic [WORD_W-1:0] word_hi,
  output logic              sdo,
  output logic              busy,
  output logic              frame_done,
  output logic              dis_status
);
  localparam int FRAME_W = 2 * WORD_W;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_PASS} st_t;

  st_t              st;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0] bits_left;
  logic [PAS_W-1:0] pas_left;
  logic             cmd_sh;
  logic             pend;

  wire [CNT_W-1:0] nb_eff  = (cmd_bits > CNT_W'(FRAME_W)) ? CNT_W'(FRAME_W) : cmd_bits;
  wire [PAS_W-1:0] pas_eff = (passive_len < PAS_W'(MIN_PASSIVE)) ? PAS_W'(MIN_PASSIVE) : passive_len;
  wire start    = (st == S_IDLE) && !chan_disable && (rep_mode || trigger || pend);
  wire zero_cmd = cmd_frame && (nb_eff == '0);

  assign busy = (st != S_IDLE);
  assign sdo  = (st == S_SHIFT) && shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      shreg      <= '0;
      bits_left  <= '0;
      pas_left   <= '0;
      cmd_sh     <= 1'b0;
      pend       <= 1'b0;
      frame_done <= 1'b0;
      dis_status <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      dis_status <= chan_disable;

      if (chan_disable || start) pend <= 1'b0;
      else if (trigger && st != S_IDLE) pend <= 1'b1;

      case (st)
        S_IDLE: if (start) begin
          cmd_sh   <= cmd_frame;
          pas_left <= pas_eff;
          shreg    <= {word_hi, word_lo};
          if (zero_cmd) frame_done <= 1'b1;
          else begin
            st        <= S_SHIFT;
            bits_left <= cmd_frame ? nb_eff : CNT_W'(FRAME_W);
          end
        end
        S_SHIFT: if (fclk_en) begin
          if (bits_left == CNT_W'(1)) begin
            if (cmd_sh) begin
              st         <= S_IDLE;
              frame_done <= 1'b1;
            end else st <= S_PASS;
          end else begin
            shreg     <= shreg >> 1;
            bits_left <= bits_left - CNT_W'(1);
          end
        end
        S_PASS: if (fclk_en) begin
          if (pas_left == PAS_W'(1)) begin
            st         <= S_IDLE;
            frame_done <= 1'b1;
          end else pas_left <= pas_left - PAS_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DIS_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    chan_disable && !busy |=> !busy); // R6
  AST_RUN_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fclk_en |=> busy); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy); // R4
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT) && $past(st == S_SHIFT) |-> $stable(pas_left) && $stable(cmd_sh)); // R5
  AST_BITS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT) |-> (bits_left != '0) && (bits_left <= CNT_W'(FRAME_W))); // R2
  AST_START_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rep_mode || trigger || pend) && !$past(chan_disable)); // R7
endmodule

// File: tb/dsf_tx_tb.sv
module dsf_tx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fclk_en = 1'b0, trigger = 1'b0, rep_mode = 1'b0, chan_disable = 1'b0, cmd_frame = 1'b0;
  logic [5:0]  cmd_bits = '0;
  logic [4:0]  passive_len = '0;
  logic [15:0] word_lo = '0, word_hi = '0;
  logic sdo, busy, frame_done, dis_status;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsf_tx dut_i (
    .clk(clk), .rst_n(rst_n), .fclk_en(fclk_en), .trigger(trigger), .rep_mode(rep_mode),
    .chan_disable(chan_disable), .cmd_frame(cmd_frame), .cmd_bits(cmd_bits),
    .passive_len(passive_len), .word_lo(word_lo), .word_hi(word_hi),
    .sdo(sdo), .busy(busy), .frame_done(frame_done), .dis_status(dis_status)
  );

  function automatic int exp_bits(bit is_cmd, int code);
    if (!is_cmd) return 32;
    return (code > 32) ? 32 : code;
  endfunction

  function automatic int exp_pas(int code);
    return (code < 3) ? 2 : code;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(bit rnd_gap);
    int gap = rnd_gap ? int'($urandom % 3) : 0;
    repeat (gap) @(negedge clk);
    fclk_en = 1'b1;
    @(negedge clk);
    fclk_en = 1'b0;
  endtask

  task automatic idle_check(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(busy == 1'b0, req, "busy while idle expected", int'(busy), 0);
    end
  endtask

  task automatic do_frame(bit is_cmd, int code, int pcode, logic [15:0] lo, logic [15:0] hi,
                          bit trig, int extra_trig, bit dis_mid, string req);
    logic [31:0] data = {hi, lo};
    int n = exp_bits(is_cmd, code);
    int p = is_cmd ? 0 : exp_pas(pcode);
    cmd_frame = is_cmd; cmd_bits = 6'(code); passive_len = 5'(pcode);
    word_lo = lo; word_hi = hi; trigger = trig;
    @(negedge clk);
    trigger = 1'b0;
    if (n == 0) begin
      chk(frame_done == 1'b1, "R3", "zero-length done", int'(frame_done), 1);
      chk(busy == 1'b0, "R3", "zero-length busy", int'(busy), 0);
      return;
    end
    chk(busy == 1'b1, req, "busy at start", int'(busy), 1);
    for (int i = 0; i < n; i++) begin
      chk(sdo == data[i], is_cmd ? "R1" : "R4", $sformatf("bit %0d", i), int'(sdo), int'(data[i]));
      chk(busy == 1'b1, "R4", "busy during shift", int'(busy), 1);
      if (i == 0) begin
        cmd_frame = ~cmd_frame; cmd_bits = 6'($urandom); passive_len = 5'($urandom);
        word_lo = 16'($urandom); word_hi = 16'($urandom);
        for (int t = 0; t < extra_trig; t++) begin
          trigger = 1'b1; @(negedge clk); trigger = 1'b0;
        end
        if (dis_mid) chan_disable = 1'b1;
      end
      pulse(1'b1);
    end
    for (int j = 0; j < p; j++) begin
      chk(sdo == 1'b0, "R4", "passive sdo", int'(sdo), 0);
      chk(busy == 1'b1, "R4", "passive busy", int'(busy), 1);
      pulse(1'b1);
    end
    chk(busy == 1'b0, is_cmd ? "R1" : "R4", "busy after end", int'(busy), 0);
    chk(frame_done == 1'b1, is_cmd ? "R1" : "R4", "done pulse", int'(frame_done), 1);
    if (dis_mid) chk(dis_status == 1'b1, "R6", "status disabled", int'(dis_status), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R10", "reset busy", int'(busy), 0);
    chk(sdo == 1'b0, "R10", "reset sdo", int'(sdo), 0);
    chk(frame_done == 1'b0, "R10", "reset done", int'(frame_done), 0);
    chk(dis_status == 1'b0, "R6", "status enabled", int'(dis_status), 0);
    idle_check(5, "R7");

    // command bit-count edges (R1, R2, R3)
    do_frame(1, 0, 0, 16'hA5A5, 16'h5A5A, 1, 0, 0, "R3");
    idle_check(2, "R3");
    do_frame(1, 1, 0, 16'h0001, 16'h0000, 1, 0, 0, "R1");
    do_frame(1, 16, 0, 16'hC3E1, 16'hFFFF, 1, 0, 0, "R1");
    do_frame(1, 17, 0, 16'h1234, 16'h0001, 1, 0, 0, "R1");
    do_frame(1, 32, 0, 16'hBEEF, 16'hDEAD, 1, 0, 0, "R1");
    do_frame(1, 33, 0, 16'h0F0F, 16'h8001, 1, 0, 0, "R2");
    do_frame(1, 63, 0, 16'h7777, 16'hF00D, 1, 0, 0, "R2");

    // passive-phase edges (R4, R5 via mid-frame scrambling)
    do_frame(0, 0, 0, 16'h1357, 16'h2468, 1, 0, 0, "R4");
    do_frame(0, 0, 1, 16'h9999, 16'h6666, 1, 0, 0, "R5");
    do_frame(0, 0, 2, 16'hFFFF, 16'h0000, 1, 0, 0, "R4");
    do_frame(0, 0, 3, 16'h0000, 16'hFFFF, 1, 0, 0, "R4");
    do_frame(0, 0, 31, 16'hAAAA, 16'h5555, 1, 0, 0, "R5");
    idle_check(4, "R7");

    // disabled: trigger ignored, status reads back (R6)
    chan_disable = 1'b1;
    trigger = 1'b1; @(negedge clk); trigger = 1'b0;
    chk(busy == 1'b0, "R6", "trigger while disabled", int'(busy), 0);
    chk(dis_status == 1'b1, "R6", "status disabled", int'(dis_status), 1);
    idle_check(3, "R6");
    chan_disable = 1'b0;
    @(negedge clk);
    chk(dis_status == 1'b0, "R6", "status re-enabled", int'(dis_status), 0);

    // pending trigger collapse (R9)
    do_frame(1, 5, 0, 16'h00F3, 16'h0000, 1, 3, 0, "R7");
    do_frame(0, 0, 4, 16'h4321, 16'h8765, 0, 0, 0, "R9");
    idle_check(6, "R9");

    // pending discarded by disable, running frame completes (R9, R6)
    do_frame(1, 8, 0, 16'h00C5, 16'h0000, 1, 1, 1, "R7");
    idle_check(4, "R9");
    chan_disable = 1'b0;
    idle_check(4, "R9");

    // repetition mode back to back, then stop via disable (R8, R6)
    rep_mode = 1'b1;
    do_frame(0, 0, 3, 16'h1111, 16'h2222, 0, 0, 0, "R8");
    do_frame(1, 12, 0, 16'h0ABC, 16'h0000, 0, 0, 0, "R8");
    do_frame(1, 40, 0, 16'h3C3C, 16'hC3C3, 0, 0, 1, "R8");
    idle_check(5, "R6");
    rep_mode = 1'b0;
    chan_disable = 1'b0;
    idle_check(3, "R7");

    // random triggered frames
    for (int k = 0; k < 60; k++) begin
      bit is_cmd = 1'($urandom);
      do_frame(is_cmd, int'($urandom % 64), int'($urandom % 32),
               16'($urandom), 16'($urandom), 1, 0, 0, "R7");
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule